// File: doc/BRIEF.md
# Serial-to-Parallel Word Demultiplexer with Bit Slip

This block sits behind a clock-and-data recovery stage. It takes a serial bit stream that is already retimed to the bit clock and packs it into 16-bit parallel words. It also produces the parallel clock, which is the bit clock divided by the word width. Two serial sources are wired in, the normal line input and a loopback path for diagnostics, and a select pin picks one of them for each bit.

An external framer hunts for the frame pattern and pulses the sync input when the pattern is not at the expected bit position. Each qualified pulse discards exactly one received bit at the start of a word, which moves the word boundary by one bit. Repeated pulses walk the alignment through all sixteen positions. The slip holds the internal bit counter for one bit time. As a result, one low phase of the parallel clock stretches by one bit, and no parallel-clock edge is dropped or added.

The serial stream is paced by the bit clock and has no way to stall, so neither edge of the block carries valid/ready handshaking and there is no back-pressure. The parallel word counts as valid at each falling edge of the parallel clock. Reset is synchronous and active high.

Top module: `bitslip_deser`

## Requirements
- R1: The parallel clock runs at the bit clock divided by 16. Without a slip it stays high for 8 bit cycles and low for 8.
- R2: With sel_loop = 0 each bit is taken from din_main. With sel_loop = 1 each bit is taken from din_loop.
- R3: The word output changes only at the bit-clock edge on which the parallel clock goes from high to low.
- R4: The first bit received for a word appears on word[15] and the last bit received appears on word[0].
- R5: A sync pulse that stays high for at least 4 consecutive bit cycles discards one received bit at the start of a word. That low phase of the parallel clock lasts 9 bit cycles instead of 8, and every later word is shifted by one bit position.
- R6: A sync pulse that stays high for fewer than 4 consecutive bit cycles has no effect on the parallel clock or on the words.
- R7: A sync pulse causes at most one slip, however long it stays high. A further slip needs sync to go low and then rise again for at least 4 cycles.
- R8: The discarded bit falls within 32 bit cycles (two parallel-clock periods) of the first bit cycle in which sync is sampled high.
- R9: While reset is high, pclk is low and word is zero. After reset is released, the first received bit starts a word, and pclk first rises after 8 bit cycles.
- R10: A change of sel_loop affects the very next sampled bit and does not move the word boundary.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bit-rate clock; the serial inputs are sampled on its rising edge |
| rst | input | 1 | Synchronous active-high reset |
| din_main | input | 1 | Normal serial data bit |
| din_loop | input | 1 | Loopback serial data bit |
| sel_loop | input | 1 | Source select: 0 normal input, 1 loopback input |
| sync_in | input | 1 | Realignment request from the framer, sampled every bit cycle |
| word | output | 16 | Assembled parallel word, first-received bit in bit 15 |
| pclk | output | 1 | Parallel clock, bit clock divided by 16 |

## Verification
A word is due at the bit-clock edge that samples its sixteenth bit, which is also the edge on which pclk falls. The first pclk rise is due 8 edges after reset is released. A qualified sync is seen on its fourth high sample, and the slip then happens at the next word start; the bench sees it as a ninth consecutive low sample of pclk, 7 edges after the slip edge. A behavioural model steps on each rising edge, and its word and pclk are compared with the design's outputs at the falling edge that follows. Directed checks count stretched pclk low phases against the pulses the bench drove, and work the slip edge back from the moment the ninth low sample is seen.

// File: rtl/bitslip_pkg.sv
package bitslip_pkg;
  localparam int DEF_WORD_W   = 16;
  localparam int DEF_SYNC_MIN = 4;

  typedef enum logic {
    SRC_MAIN = 1'b0,
    SRC_LOOP = 1'b1
  } src_e;
endpackage

// File: rtl/bitslip_src_sel.sv
module bitslip_src_sel
  import bitslip_pkg::*;
(
  input  logic sel,
  input  logic din_main,
  input  logic din_loop,
  output logic bit_out
);
  src_e src;

  assign src = src_e'(sel);

  always_comb begin
    unique case (src)
      SRC_LOOP: bit_out = din_loop;
      default:  bit_out = din_main;
    endcase
  end
endmodule

// File: rtl/bitslip_sync_qual.sv
// Qualifies the realignment request: one pulse on the SYNC_MIN-th
// consecutive high sample, and never again until sync goes low.
module bitslip_sync_qual #(
  parameter int SYNC_MIN = 4
) (
  input  logic clk,
  input  logic rst,
  input  logic sync_in,
  output logic fire
);
  localparam int SW = $clog2(SYNC_MIN + 1);

  logic [SW-1:0] hi_cnt;

  assign fire = sync_in && (hi_cnt == SW'(SYNC_MIN - 1));

  always_ff @(posedge clk) begin
    if (rst || !sync_in) begin
      hi_cnt <= '0;
    end else if (hi_cnt != SW'(SYNC_MIN)) begin
      hi_cnt <= hi_cnt + 1'b1;
    end
  end
endmodule

// File: rtl/bitslip_phase_ctr.sv
// Bit position counter. A pending slip is taken only at a word start:
// the counter then holds at zero for one bit time.
module bitslip_phase_ctr #(
  parameter int WORD_W = 16
) (
  input  logic clk,
  input  logic rst,
  input  logic slip_req,
  output logic capture,
  output logic pclk
);
  localparam int CW   = $clog2(WORD_W);
  localparam int HALF = WORD_W / 2;

  logic [CW-1:0] cnt;
  logic          pend;
  logic          take;

  assign take    = pend && (cnt == '0);
  assign capture = (cnt == CW'(WORD_W - 1));
  assign pclk    = (cnt >= CW'(HALF));

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt  <= '0;
      pend <= 1'b0;
    end else begin
      pend <= (pend && !take) || slip_req;
      if (!take) begin
        cnt <= capture ? '0 : cnt + 1'b1;
      end
    end
  end
endmodule

// File: rtl/bitslip_word_asm.sv
// Shifts bits in at the low end, so the oldest bit ends up at the MSB.
module bitslip_word_asm #(
  parameter int WORD_W = 16
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              bit_in,
  input  logic              capture,
  output logic [WORD_W-1:0] word
);
  logic [WORD_W-2:0] sr;

  always_ff @(posedge clk) begin
    if (rst) begin
      sr   <= '0;
      word <= '0;
    end else begin
      sr <= {sr[WORD_W-3:0], bit_in};
      if (capture) begin
        word <= {sr, bit_in};
      end
    end
  end
endmodule

// File: rtl/bitslip_deser.sv
module bitslip_deser
  import bitslip_pkg::*;
#(
  parameter int WORD_W   = DEF_WORD_W,
  parameter int SYNC_MIN = DEF_SYNC_MIN
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              din_main,
  input  logic              din_loop,
  input  logic              sel_loop,
  input  logic              sync_in,
  output logic [WORD_W-1:0] word,
  output logic              pclk
);
  logic ser_bit;
  logic fire;
  logic capture;

  bitslip_src_sel u_src (
    .sel      (sel_loop),
    .din_main (din_main),
    .din_loop (din_loop),
    .bit_out  (ser_bit)
  );

  bitslip_sync_qual #(.SYNC_MIN(SYNC_MIN)) u_qual (
    .clk     (clk),
    .rst     (rst),
    .sync_in (sync_in),
    .fire    (fire)
  );

  bitslip_phase_ctr #(.WORD_W(WORD_W)) u_phase (
    .clk      (clk),
    .rst      (rst),
    .slip_req (fire),
    .capture  (capture),
    .pclk     (pclk)
  );

  bitslip_word_asm #(.WORD_W(WORD_W)) u_asm (
    .clk     (clk),
    .rst     (rst),
    .bit_in  (ser_bit),
    .capture (capture),
    .word    (word)
  );
endmodule

// File: rtl/bitslip_deser_chk.sv
module bitslip_deser_chk #(
  parameter int WORD_W = 16
) (
  input logic              clk,
  input logic              rst,
  input logic              pclk,
  input logic [WORD_W-1:0] word
);
  localparam int HALF = WORD_W / 2;
  localparam int RW   = $clog2(WORD_W + 2) + 1;

  logic [RW-1:0] lo_run;
  logic [RW-1:0] hi_run;
  logic          rst_d = 1'b0;

  always_ff @(posedge clk) begin
    rst_d <= rst;
    if (rst) begin
      lo_run <= '0;
      hi_run <= '0;
    end else if (pclk) begin
      lo_run <= '0;
      if (hi_run != '1) hi_run <= hi_run + 1'b1;
    end else begin
      hi_run <= '0;
      if (lo_run != '1) lo_run <= lo_run + 1'b1;
    end
  end

  always @(posedge clk) begin
    if (rst_d) begin
      assert_reset_R9: assert (!pclk && word == '0);
    end
  end

  assert_word_on_fall_R3: assert property (@(posedge clk) disable iff (rst)
    !$stable(word) |-> $fell(pclk));

  assert_high_phase_R1: assert property (@(posedge clk) disable iff (rst)
    $fell(pclk) |-> (hi_run == RW'(HALF)));

  assert_low_phase_R5: assert property (@(posedge clk) disable iff (rst)
    $rose(pclk) |-> (lo_run == RW'(HALF) || lo_run == RW'(HALF + 1)));
endmodule

bind bitslip_deser bitslip_deser_chk #(.WORD_W(WORD_W)) u_chk (
  .clk  (clk),
  .rst  (rst),
  .pclk (pclk),
  .word (word)
);

// File: tb/bitslip_deser_bench.sv
module bitslip_deser_bench;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        din_main = 1'b0;
  logic        din_loop = 1'b0;
  logic        sel_loop = 1'b0;
  logic        sync_in = 1'b0;
  logic [15:0] word;
  logic        pclk;

  always #10 clk = ~clk;

  bitslip_deser u_bitslip_deser (
    .clk      (clk),
    .rst      (rst),
    .din_main (din_main),
    .din_loop (din_loop),
    .sel_loop (sel_loop),
    .sync_in  (sync_in),
    .word     (word),
    .pclk     (pclk)
  );

  int checks = 0;
  int fails = 0;
  int cyc = 0;
  bit started = 0;
  bit done = 0;

  // behavioural reference
  int          m_phase = 0;
  int          m_run = 0;
  bit          m_pend = 0;
  logic [15:0] m_word = '0;
  bit          hist[$];

  always @(posedge clk) begin
    bit b, fire, slip;
    cyc++;
    started = 1;
    if (rst) begin
      m_phase = 0; m_run = 0; m_pend = 0; m_word = '0;
      hist.delete();
    end else begin
      b = sel_loop ? din_loop : din_main;
      hist.push_back(b);
      if (hist.size() > 16) void'(hist.pop_front());
      m_run = sync_in ? m_run + 1 : 0;
      fire = (m_run == 4);
      slip = m_pend && (m_phase == 0);
      m_pend = (m_pend && !slip) || fire;
      if (!slip) begin
        if (m_phase == 15) begin
          for (int i = 0; i < 16; i++) m_word[15-i] = hist[i];
          m_phase = 0;
        end else begin
          m_phase++;
        end
      end
    end
  end

  // per-cycle comparison and slip observation at the falling edge
  int          lowrun = 0;
  int          stretches = 0;
  int          stretch_cyc = 0;
  logic [15:0] prev_word = '0;
  logic        prev_pclk = 1'b0;

  always @(negedge clk) begin
    if (started && !done) begin
      checks++;
      if (word !== m_word) begin
        fails++;
        $display("FAIL R4 word got %h exp %h at cycle %0d", word, m_word, cyc);
      end
      checks++;
      if (pclk !== (m_phase >= 8)) begin
        fails++;
        $display("FAIL R1 pclk got %0d exp %0d at cycle %0d", pclk, (m_phase >= 8), cyc);
      end
      checks++;
      if (word !== prev_word && !(prev_pclk && !pclk)) begin
        fails++;
        $display("FAIL R3 word changed off pclk fall got %h exp %h", word, prev_word);
      end
      prev_word = word;
      prev_pclk = pclk;
      if (rst) lowrun = 0;
      else if (!pclk) begin
        lowrun++;
        if (lowrun == 9) begin stretches++; stretch_cyc = cyc; end
      end else lowrun = 0;
    end
  end

  task automatic check(input string req, input int got, input int exp);
    checks++;
    if (got != exp) begin
      fails++;
      $display("FAIL %s got %0d exp %0d", req, got, exp);
    end
  endtask

  task automatic drive_bit(input bit m, input bit l, input bit s, input bit sy);
    din_main = m; din_loop = l; sel_loop = s; sync_in = sy;
    @(negedge clk);
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) drive_bit(1'($urandom), 1'($urandom), 0, 0);
  endtask

  task automatic finish_run();
    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  endtask

  initial begin
    #(20 * 150000);
    fails++;
    $display("FAIL watchdog expired");
    finish_run();
  end

  initial begin
    logic [15:0] pat;
    int first_rise, s0, rise;
    repeat (3) @(negedge clk);
    // R9: reset state
    check("R9 pclk in reset", int'(pclk), 0);
    check("R9 word in reset", int'(word), 0);
    rst = 1'b0;

    // R4 / R2: main source, word bit order, first pclk rise
    pat = 16'hA5C3;
    first_rise = -1;
    for (int k = 0; k < 16; k++) begin
      if (pclk && first_rise < 0) first_rise = k;
      drive_bit(pat[15-k], ~pat[15-k], 0, 0);
    end
    check("R9 first pclk rise bit", first_rise, 8);
    check("R4 first word main", int'(word), int'(16'hA5C3));

    // R2: loopback source
    pat = 16'h3C96;
    for (int k = 0; k < 16; k++) drive_bit(~pat[15-k], pat[15-k], 1, 0);
    check("R2 loopback word", int'(word), int'(16'h3C96));

    // R10: source switch mid word
    for (int k = 0; k < 16; k++) drive_bit(1, 0, (k >= 8), 0);
    check("R10 mixed-source word", int'(word), int'(16'hFF00));
    check("R10 no slip on select change", stretches, 0);

    // R6: three-cycle pulse ignored
    for (int k = 0; k < 3; k++) drive_bit(1'($urandom), 1'($urandom), 0, 1);
    idle(40);
    check("R6 short sync no slip", stretches, 0);

    // R5 / R8: four-cycle pulse
    s0 = stretches;
    rise = cyc + 1;
    for (int k = 0; k < 4; k++) drive_bit(1'($urandom), 1'($urandom), 0, 1);
    idle(40);
    check("R5 one slip for qualified sync", stretches, s0 + 1);
    checks++;
    if ((stretch_cyc - 7) - rise > 32) begin
      fails++;
      $display("FAIL R8 slip latency got %0d exp <= 32", (stretch_cyc - 7) - rise);
    end

    // R7: long pulse gives a single slip, a new rise gives another
    s0 = stretches;
    for (int k = 0; k < 40; k++) drive_bit(1'($urandom), 1'($urandom), 0, 1);
    idle(40);
    check("R7 long sync single slip", stretches, s0 + 1);
    for (int k = 0; k < 6; k++) drive_bit(1'($urandom), 1'($urandom), 0, 1);
    idle(40);
    check("R7 second rise slips again", stretches, s0 + 2);

    // mixed traffic with random pulses (R5, R6, R2)
    s0 = stretches;
    for (int j = 0; j < 50; j++) begin
      int w;
      w = 1 + int'($urandom % 20);
      if (w >= 4) s0++;
      for (int k = 0; k < 60; k++)
        drive_bit(1'($urandom), 1'($urandom), 1'($urandom), (k < w));
    end
    idle(40);
    check("R5 random traffic slip count", stretches, s0);
    finish_run();
  end
endmodule